// File: doc/BRIEF.md
# Serial Control and Readback Slave for a Data-Line Decoder

This block is the two-wire serial slave of a broadcast data-line decoder. It watches the SCL and SDA lines using the fast system clock. A bus master can write one control byte, which selects the operating mode of the acquisition logic. The master can also read back, in a fixed order, the bytes that the acquisition logic last stored. The slave drives SDA only by pulling it low, through an enable output, and it never stretches the clock.

The acquisition side offers a complete 16-byte record on a parallel port and pulses a load strobe. The record is taken into the buffer only while no master is talking to this slave. A strobe that arrives during a bus access is dropped, not queued, and the next received data line brings the next update. A busy output tells the acquisition side when the bus is holding off updates. The block has no sub-address. A START condition points the read cursor at byte 0, and every master acknowledge moves it one byte on.

Top module: `i2c_acq_regif`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0x10 with `addr_sel_i` added in the least significant bit. That gives 0x20/0x21 for write/read when `addr_sel_i`=0, and 0x22/0x23 when it is 1. Any other address is not acknowledged and changes nothing.
- R2: After an acknowledged write address, the next byte is acknowledged and stored in the control register. It appears on `ctrl_o`.
- R3: The decoded outputs follow fixed bits of the control register: bit 0 is `src_alt_o`, bit 1 is `pkt_mode_o` (0 = dedicated-line mode), bit 2 is `hdr_sel_o`, bit 3 is `hdr_order_o`, and bits 7:4 are `test_bits_o`.
- R4: After reset, the control register is 0x00, SDA is released, and `busy_o` is low.
- R5: Every START, including a repeated START, sets the read cursor to byte 0. Byte k of the buffer is bits [8k+7:8k] of `ld_data_i`.
- R6: In a read, each byte is sent most significant bit first. A master ACK advances the cursor to the next byte.
- R7: A master NACK ends the read. The slave keeps SDA released until the next START.
- R8: A read beyond the 16th byte returns 0xFF. The cursor saturates and does not wrap.
- R9: `busy_o` rises on START. It stays high through an addressed transaction until STOP. It falls once an address byte fails to match.
- R10: A load strobe that the block samples while `busy_o` is low replaces the whole buffer. One sampled while `busy_o` is high is discarded and never applied later.
- R11: In a write, bytes after the first control byte are not acknowledged and do not change the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 1 | Selects one of two slave address pairs |
| ld_stb_i | input | 1 | Acquisition load strobe, one clock wide |
| ld_data_i | input | 128 | New record, byte k in bits [8k+7:8k] |
| busy_o | output | 1 | Bus access in progress; loads are blocked |
| ctrl_o | output | 8 | Raw control register |
| src_alt_o | output | 1 | Control bit 0 |
| pkt_mode_o | output | 1 | Control bit 1 |
| hdr_sel_o | output | 1 | Control bit 2 |
| hdr_order_o | output | 1 | Control bit 3 |
| test_bits_o | output | 4 | Control bits 7:4 |

## Verification
The acquisition load and the START detection that raises the busy flag can fall in the same system clock cycle. This race decides whether a record reaches the buffer. The bench lowers SDA while SCL is high, then fires the load strobe after a delay that it sweeps over several clocks. It records `busy_o` on the edge where the strobe is sampled. After the access it reads byte 0 and expects the new record only if busy was low at that edge. The sweep must produce both an accepted and a discarded load.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } link_st_e;

  // Control byte layout; downstream acquisition logic depends on these positions.
  typedef struct packed {
    logic [3:0] test;
    logic       hdr_order;
    logic       hdr_sel;
    logic       pkt_mode;
    logic       src_alt;
  } ctrl_t;

  function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic sel);
    return base | {6'd0, sel};
  endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sda_val,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-2:0], scl};
      sda_p <= {sda_p[SYNC_STAGES-2:0], sda};
      scl_d <= scl_p[LAST];
      sda_d <= sda_p[LAST];
    end
  end

  assign sda_val   = sda_p[LAST];
  assign start_evt = scl_p[LAST] & scl_d & sda_d & ~sda_p[LAST];
  assign stop_evt  = scl_p[LAST] & scl_d & ~sda_d & sda_p[LAST];
  assign scl_rise  = scl_p[LAST] & ~scl_d;
  assign scl_fall  = ~scl_p[LAST] & scl_d;

endmodule

// File: rtl/i2cr_byte_store.sv
module i2cr_byte_store #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_stb,
  input  logic [NBYTES*8-1:0]   ld_data,
  input  logic                  hold,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_byte
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBYTES);

  logic [NBYTES*8-1:0] mem_q;
  logic                ld_take;

  assign ld_take = ld_stb & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (ld_take) mem_q <= ld_data;
  end

  assign rd_byte = (rd_idx < IDX_END) ? mem_q[rd_idx*8 +: 8] : 8'hFF;

  // R10: a strobe during a bus access leaves the buffer untouched
  p_busy_blocks_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && hold) |=> $stable(mem_q));
  // R10: a strobe while idle takes the full record
  p_idle_load_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !hold) |=> (mem_q == $past(ld_data)));
  // R8: beyond the record the read byte is all ones
  p_past_end_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_END) |-> (rd_byte == 8'hFF));

endmodule

// File: rtl/i2cr_link_fsm.sv
module i2cr_link_fsm
  import i2cr_pkg::*;
#(
  parameter int         NBYTES    = 16,
  parameter int         IDX_W     = 5,
  parameter logic [6:0] BASE_ADDR = 7'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_val,
  input  logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_oe,
  output logic             busy,
  output logic [7:0]       ctrl
);
  localparam logic [IDX_W-1:0] PTR_END = IDX_W'(NBYTES);

  link_st_e         st;
  logic [7:0]       sh;
  logic [3:0]       bcnt;
  logic [IDX_W-1:0] ptr;
  logic             rw, mack;

  logic addr_hit, byte_done, wr_commit, addr_miss;

  function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
    return (p >= PTR_END) ? PTR_END : p + 1'b1;
  endfunction

  assign addr_hit  = (sh[7:1] == dev_addr(BASE_ADDR, addr_sel));
  assign byte_done = scl_fall && (bcnt == 4'd8);
  assign wr_commit = (st == ST_WDAT) && byte_done && !start_evt && !stop_evt;
  assign addr_miss = (st == ST_ADDR) && byte_done && !addr_hit && !start_evt && !stop_evt;
  assign rd_idx    = (st == ST_RACK) ? ptr_step(ptr) : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; bcnt <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; busy <= 1'b0; ctrl <= '0;
    end else if (start_evt) begin
      st <= ST_ADDR; bcnt <= '0; ptr <= '0; busy <= 1'b1; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE; busy <= 1'b0; sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise && bcnt != 4'd8) begin
            sh   <= {sh[6:0], sda_val};
            bcnt <= bcnt + 4'd1;
          end else if (byte_done) begin
            bcnt <= '0;
            if (st == ST_WDAT) begin
              ctrl <= sh; st <= ST_WACK; sda_oe <= 1'b1;
            end else if (addr_hit) begin
              rw <= sh[0]; st <= ST_AACK; sda_oe <= 1'b1;
            end else begin
              st <= ST_SKIP; busy <= 1'b0;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw) begin
            st <= ST_RDAT; sh <= rd_byte; sda_oe <= ~rd_byte[7];
          end else begin
            st <= ST_WDAT; sda_oe <= 1'b0;
          end
        end
        ST_WACK: if (scl_fall) begin
          st <= ST_SKIP; sda_oe <= 1'b0;
        end
        ST_RDAT: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            st <= ST_RACK; sda_oe <= 1'b0; bcnt <= '0;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bcnt <= bcnt + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_val;
          else if (scl_fall) begin
            if (mack) begin
              ptr <= ptr_step(ptr); sh <= rd_byte; sda_oe <= ~rd_byte[7]; st <= ST_RDAT;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R5: START puts the cursor back on byte 0
  p_start_clears_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ptr == '0));
  // R8: the cursor never runs past the end marker
  p_ptr_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr <= PTR_END));
  // R9: the slave only drives SDA inside an access that holds the bus
  p_drive_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  // R9: a mismatched address releases the busy flag
  p_miss_drops_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !busy);
  // R7: after the transfer is over the line stays released
  p_silent_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe);
  // R2/R11: the control register changes only on the first write data byte
  p_ctrl_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(wr_commit));

endmodule

// File: rtl/i2c_acq_regif.sv
module i2c_acq_regif
  import i2cr_pkg::*;
#(
  parameter int         NBYTES      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic                addr_sel_i,
  input  logic                ld_stb_i,
  input  logic [NBYTES*8-1:0] ld_data_i,
  output logic                busy_o,
  output logic [7:0]          ctrl_o,
  output logic                src_alt_o,
  output logic                pkt_mode_o,
  output logic                hdr_sel_o,
  output logic                hdr_order_o,
  output logic [3:0]          test_bits_o
);
  localparam int IDX_W = $clog2(NBYTES + 1);

  logic             sda_val, start_evt, stop_evt, scl_rise, scl_fall;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic             busy;
  logic [7:0]       ctrl_q;
  ctrl_t            cf;

  i2cr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl(scl_i), .sda(sda_i),
    .sda_val(sda_val), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cr_link_fsm #(.NBYTES(NBYTES), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel_i),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_val(sda_val), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .sda_oe(sda_oe_o), .busy(busy), .ctrl(ctrl_q)
  );

  i2cr_byte_store #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb_i), .ld_data(ld_data_i),
    .hold(busy), .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  assign cf          = ctrl_t'(ctrl_q);
  assign busy_o      = busy;
  assign ctrl_o      = ctrl_q;
  assign src_alt_o   = cf.src_alt;
  assign pkt_mode_o  = cf.pkt_mode;
  assign hdr_sel_o   = cf.hdr_sel;
  assign hdr_order_o = cf.hdr_order;
  assign test_bits_o = cf.test;

  // R4: out of reset the slave leaves SDA alone and holds no bus
  p_reset_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe_o && !busy_o && ctrl_o == 8'h00));

endmodule

// File: tb/tb_i2c_acq_regif.sv
module tb_i2c_acq_regif;
  localparam int NB = 16;
  localparam int Q  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0, ld_stb = 1'b0;
  logic [NB*8-1:0] ld_data = '0;
  wire             sda_oe, busy, src_alt, pkt_mode, hdr_sel, hdr_order;
  wire [7:0]       ctrl;
  wire [3:0]       tbits;
  wire             sda_line = sda_m & ~sda_oe;

  i2c_acq_regif dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .ld_stb_i(ld_stb), .ld_data_i(ld_data), .busy_o(busy),
    .ctrl_o(ctrl), .src_alt_o(src_alt), .pkt_mode_o(pkt_mode), .hdr_sel_o(hdr_sel),
    .hdr_order_o(hdr_order), .test_bits_o(tbits)
  );

  int checks = 0, fails = 0;
  logic [NB*8-1:0] img = '0;
  logic [7:0]      ctrl_exp = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return (i < NB) ? img[i*8 +: 8] : 8'hFF;
  endfunction

  function automatic logic [7:0] wr_addr(input logic s);
    return s ? 8'h22 : 8'h20;
  endfunction

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~ack);
  endtask

  task automatic load_idle(input logic [NB*8-1:0] d);
    @(negedge clk); ld_data = d; ld_stb = 1'b1;
    @(negedge clk); ld_stb = 1'b0;
    img = d;
  endtask

  task automatic wr_ctrl(input logic [7:0] ab, input logic [7:0] d, output logic a1, output logic a2);
    i2c_start(); send(ab, a1);
    if (a1) send(d, a2); else a2 = 1'b0;
    i2c_stop();
  endtask

  task automatic rd_seq(input int n, input string tag);
    logic a; logic [7:0] v;
    i2c_start(); send(wr_addr(sel) | 8'h01, a);
    chk("R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv(v, i != n - 1);
      chk(tag, v, exp_rd(i));
    end
    i2c_stop();
  endtask

  task automatic chk_fields();
    chk("R2 ctrl value", ctrl, ctrl_exp);
    chk("R3 bit0 src_alt", src_alt, ctrl_exp[0]);
    chk("R3 bit1 pkt_mode", pkt_mode, ctrl_exp[1]);
    chk("R3 bit2 hdr_sel", hdr_sel, ctrl_exp[2]);
    chk("R3 bit3 hdr_order", hdr_order, ctrl_exp[3]);
    chk("R3 bits7:4 test", tbits, ctrl_exp[7:4]);
  endtask

  function automatic logic [NB*8-1:0] rnd_rec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic a1, a2, b;
    logic [7:0] v;
    int acc, rej;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 reset state
    chk("R4 ctrl after reset", ctrl, 8'h00);
    chk("R4 sda released", sda_oe, 0);
    chk("R4 busy low", busy, 0);
    chk_fields();

    // R1/R2/R3 write with both address selections
    wr_ctrl(8'h20, 8'hA5, a1, a2);
    chk("R1 write address ack", a1, 1); chk("R2 data ack", a2, 1);
    ctrl_exp = 8'hA5; chk_fields();
    wr_ctrl(8'h20, 8'h5A, a1, a2); ctrl_exp = 8'h5A; chk_fields();
    wr_ctrl(8'h22, 8'hFF, a1, a2);
    chk("R1 foreign address nack", a1, 0); chk("R1 ctrl unchanged", ctrl, ctrl_exp);
    chk("R9 busy low after miss", busy, 0);
    sel = 1'b1;
    wr_ctrl(8'h22, 8'h3C, a1, a2); chk("R1 sel=1 ack", a1, 1);
    ctrl_exp = 8'h3C; chk_fields();
    wr_ctrl(8'h20, 8'h00, a1, a2); chk("R1 sel=1 rejects 0x20", a1, 0);
    chk("R1 ctrl kept", ctrl, ctrl_exp);
    sel = 1'b0;

    // R11 extra write byte
    i2c_start(); send(8'h20, a1); send(8'h0F, a2); send(8'hF0, b);
    chk("R11 second data byte nack", b, 0);
    i2c_stop(); ctrl_exp = 8'h0F; chk("R11 ctrl keeps first byte", ctrl, ctrl_exp);

    // R5/R6 full read, R8 past the end
    load_idle(rnd_rec());
    rd_seq(16, "R6 sequential byte");
    rd_seq(20, "R8 read past end");

    // R7/R9 NACK then silence, busy held until STOP
    load_idle({{(NB-2){8'h00}}, 8'h00, 8'h81});
    i2c_start(); chk("R9 busy after START", busy, 1);
    send(8'h21, a1); recv(v, 1'b0); chk("R5 first byte", v, 8'h81);
    recv(v, 1'b0); chk("R7 released after NACK", v, 8'hFF);
    chk("R9 busy until STOP", busy, 1);
    i2c_stop(); chk("R9 busy cleared by STOP", busy, 0);

    // R5 repeated START after NACK
    load_idle(rnd_rec());
    i2c_start(); send(8'h21, a1);
    recv(v, 1'b1); recv(v, 1'b0); chk("R6 second byte", v, exp_rd(1));
    i2c_start(); send(8'h21, a1); recv(v, 1'b0);
    chk("R5 repeated START restarts at 0", v, exp_rd(0));
    i2c_stop();

    // R10 load during access is dropped and not replayed
    i2c_start(); send(8'h21, a1);
    @(negedge clk); ld_data = ~img; ld_stb = 1'b1; @(negedge clk); ld_stb = 1'b0;
    recv(v, 1'b1); chk("R10 busy load dropped (in access)", v, exp_rd(0));
    recv(v, 1'b0); chk("R10 busy load dropped (byte1)", v, exp_rd(1));
    i2c_stop();
    rd_seq(2, "R10 no replay after STOP");
    load_idle(~img); rd_seq(3, "R10 idle load taken");

    // R10 race between strobe and START detection
    acc = 0; rej = 0;
    for (int off = 0; off < 8; off++) begin
      load_idle(rnd_rec());
      @(negedge clk); sda_m = 1'b0;
      repeat (off) @(negedge clk);
      b = busy; ld_data = rnd_rec(); ld_stb = 1'b1;
      @(negedge clk); ld_stb = 1'b0;
      if (!b) begin img = ld_data; acc++; end else rej++;
      qw(); scl_m = 1'b0; qw();
      send(8'h21, a1); recv(v, 1'b0);
      chk("R10 race outcome byte0", v, exp_rd(0));
      i2c_stop();
    end
    chk("R10 race saw both outcomes", (acc > 0) && (rej > 0), 1);

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [7:0] bad;
      sel = 1'($urandom);
      load_idle(rnd_rec());
      v = 8'($urandom);
      wr_ctrl(wr_addr(sel), v, a1, a2);
      chk("R1 random ack", a1, 1); ctrl_exp = v; chk_fields();
      do bad = 8'($urandom); while (bad[7:1] == wr_addr(sel) >> 1);
      wr_ctrl(bad, 8'h99, a1, a2);
      chk("R1 random foreign nack", a1, 0); chk("R1 random ctrl kept", ctrl, ctrl_exp);
      rd_seq(1 + int'($urandom % 20), "R6 random read");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule